// File: doc/BRIEF.md
# Serial Register-File Slave with Burst Auto-Increment

The block is a serial-port slave that gives a serial master read and write access to a bank of twelve byte-wide configuration registers. The master frames each transfer with an active-low chip select and clocks it with a serial clock in SPI mode 0. The slave samples its data input on the rising clock edge and changes its data output on the falling edge. The first byte of every transfer is the command: seven address bits, most significant first, followed by one operation bit (0 = write, 1 = read). Every further byte in the same chip-select window is a data byte, sent most significant bit first. After each byte the register pointer moves to the next register, and it goes back to register 0 once it has passed register 11. The whole register bank is also presented in parallel, so that the logic it configures can read it directly.

All serial inputs are brought into the system clock domain through synchronizers, and a small state machine then decodes the transfer. Its states are IDLE (chip select inactive), ADDR (command byte being shifted in), WDATA (write burst) and RDATA (read burst). The transitions are: IDLE to ADDR when chip select becomes active; ADDR to WDATA or to RDATA on the eighth rising clock edge, chosen by the operation bit; any state to IDLE when chip select goes inactive. WDATA and RDATA hold until chip select is released. The serial output has a separate output-enable pin, which an external tri-state pad cell uses.

Top module: `spi_rf_slave`

## Requirements
- R1: After reset every register reads 0x00 on the parallel view, and `sdo_oe` is low.
- R2: A command byte made of address A6..A0 followed by operation bit 0, then one data byte D7..D0, writes that byte to the addressed register. Register i appears on `regs[8*i+7:8*i]`.
- R3: In a write burst, data byte n (counting from 0) goes to register Addr0 + n.
- R4: When the pointer advances from register 11 or from any higher address, it becomes 0. A write burst starting at 10 therefore fills registers 10, 11 and 0.
- R5: A command byte with operation bit 1 makes the slave return the contents of register Addr0 on `sdo`, most significant bit first. Each bit changes on a falling SCLK edge, starting with the falling edge that follows the operation bit.
- R6: In a read burst, data byte n returns register Addr0 + n, and the wrap rule of R4 applies.
- R7: After a read command, SDI is ignored until chip select is released: no register changes, whatever SDI carries.
- R8: `sdo_oe` is low during the command byte, during write bursts and whenever `cs_n` is high. It goes low in the same cycle that `cs_n` goes high. It is high during the data bytes of a read burst.
- R9: A write takes effect only once all eight data bits have been received. A partial data byte at chip-select release changes nothing.
- R10: Addresses 12 to 127 do not exist. Writes to them change nothing and reads from them return 0x00.
- R11: Releasing chip select clears the bit and byte counters. A transfer cut short inside the command byte does not disturb the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| regs | output | NREG*DW | Parallel view of all registers, register 0 in the low byte |

## Verification
The bench aims at the pointer wrap from both sides. A write burst crosses register 11, and a read burst starts at an address that does not exist. A design that wrapped at the wrong value, or failed to wrap from high addresses, would put bytes into the wrong register or read back garbage. It sends 0xFF bytes on SDI during a read burst; a design that kept decoding SDI would overwrite registers. It cuts transfers short in the middle of both the command byte and a data byte. A design with sticky counters would then misalign the next transfer, and one that wrote early would commit a half-shifted byte. The bench also watches the output enable bit by bit, which exposes a pad that drives during writes or that lingers after chip select is released.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } spi_state_e;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b100;

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_prev;

    assign raw = {cs_n, sclk, sdi};

    for (genvar b = 0; b < NSIG; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], raw[b]};
            end
        end
        assign synced[b] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= synced[1];
        end
    end

    assign cs_act    = ~synced[2];
    assign sdi_s     = synced[0];
    assign sclk_rise = synced[1] & ~sclk_prev;
    assign sclk_fall = ~synced[1] & sclk_prev;

endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
    import spi_rf_pkg::*;
#(
    parameter int NREG = 12,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_act,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic            sdi_s,
    output spi_state_e      state,
    output logic [DW-2:0]   ptr,
    output logic            ptr_adv,
    output logic            wr_en,
    output logic [DW-1:0]   wr_data,
    output logic            tx_load,
    output logic            tx_shift
);
    localparam int AW   = DW - 1;
    localparam int BCW  = $clog2(DW);
    localparam int LAST = NREG - 1;

    spi_state_e       state_q, state_d;
    logic [BCW-1:0]   bit_cnt;
    logic [DW-2:0]    shreg;
    logic             last_bit;
    logic [AW-1:0]    ptr_next;

    assign last_bit = (bit_cnt == BCW'(DW - 1));
    assign ptr_next = (ptr >= AW'(LAST)) ? '0 : ptr + AW'(1);
    assign state    = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_ADDR;
                ST_ADDR:  if (sclk_rise && last_bit) state_d = sdi_s ? ST_RDATA : ST_WDATA;
                ST_WDATA: state_d = ST_WDATA;
                ST_RDATA: state_d = ST_RDATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // output strobes
    always_comb begin
        wr_en    = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        ptr_adv  = 1'b0;
        wr_data  = {shreg, sdi_s};
        if (cs_act) begin
            unique case (state_q)
                ST_WDATA: begin
                    wr_en   = sclk_rise && last_bit;
                    ptr_adv = sclk_rise && last_bit;
                end
                ST_RDATA: begin
                    ptr_adv  = sclk_rise && last_bit;
                    tx_load  = sclk_fall && (bit_cnt == '0);
                    tx_shift = sclk_fall && (bit_cnt != '0);
                end
                default: ;
            endcase
        end
    end

    // bit counter, input shifter and register pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
        end else if (!cs_act) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sclk_rise && state_q != ST_IDLE) begin
            bit_cnt <= last_bit ? '0 : bit_cnt + BCW'(1);
            if (state_q != ST_RDATA) begin
                shreg <= {shreg[DW-3:0], sdi_s};
            end
            if (last_bit) begin
                if (state_q == ST_ADDR) begin
                    ptr <= shreg[AW-1:0];
                end else begin
                    ptr <= ptr_next;
                end
            end
        end
    end

endmodule

// File: rtl/spi_rf_regbank.sv
module spi_rf_regbank #(
    parameter int NREG = 12,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DW-2:0]      addr,
    input  logic [DW-1:0]      wr_data,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs
);
    localparam int AW = DW - 1;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i*DW +: DW] <= '0;
            end else if (wr_en && addr == AW'(i)) begin
                regs[i*DW +: DW] <= wr_data;
            end
        end
    end

    // unmatched addresses fall through to zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr == AW'(i)) rd_data = regs[i*DW +: DW];
        end
    end

endmodule

// File: rtl/spi_rf_tx.sv
module spi_rf_tx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          cs_n,
    input  logic          load,
    input  logic          shift,
    input  logic [DW-1:0] load_data,
    output logic          sdo,
    output logic          sdo_oe
);
    logic [DW-1:0] tx;
    logic          oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx   <= '0;
            oe_q <= 1'b0;
        end else if (!cs_act) begin
            tx   <= '0;
            oe_q <= 1'b0;
        end else if (load) begin
            tx   <= load_data;
            oe_q <= 1'b1;
        end else if (shift) begin
            tx <= {tx[DW-2:0], 1'b0};
        end
    end

    // raw chip select cuts the driver without waiting for the synchronizer
    assign sdo_oe = oe_q & ~cs_n;
    assign sdo    = sdo_oe & tx[DW-1];

endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
    import spi_rf_pkg::*;
#(
    parameter int NREG   = 12,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [NREG*DW-1:0] regs
);
    localparam int AW = DW - 1;

    logic          cs_act, sclk_rise, sclk_fall, sdi_s;
    spi_state_e    state;
    logic [AW-1:0] ptr;
    logic          ptr_adv, wr_en, tx_load, tx_shift;
    logic [DW-1:0] wr_data, rd_data;

    spi_rf_sync #(.STAGES(STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s)
    );

    spi_rf_ctrl #(.NREG(NREG), .DW(DW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .state     (state),
        .ptr       (ptr),
        .ptr_adv   (ptr_adv),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift)
    );

    spi_rf_regbank #(.NREG(NREG), .DW(DW)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .regs    (regs)
    );

    spi_rf_tx #(.DW(DW)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .cs_n      (cs_n),
        .load      (tx_load),
        .shift     (tx_shift),
        .load_data (rd_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker
    import spi_rf_pkg::*;
#(
    parameter int NREG = 12,
    parameter int DW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sdo,
    input logic               sdo_oe,
    input logic               sclk_fall,
    input spi_state_e         state,
    input logic [DW-2:0]      ptr,
    input logic               ptr_adv,
    input logic               wr_en,
    input logic [DW-1:0]      wr_data,
    input logic [NREG*DW-1:0] regs
);
    localparam int AW   = DW - 1;
    localparam int LAST = NREG - 1;

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr < AW'(NREG)) |=> regs[$past(ptr)*DW +: DW] == $past(wr_data));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && ptr < AW'(LAST)) |=> ptr == $past(ptr) + AW'(1));

    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && ptr >= AW'(LAST)) |=> ptr == '0);

    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$stable(sdo)) |-> $past(sclk_fall));

    p_read_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA) |=> $stable(regs));

    p_no_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA || state == ST_IDLE || state == ST_ADDR) |-> !sdo_oe);

    p_bad_addr_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr >= AW'(NREG)) |=> $stable(regs));

endmodule

bind spi_rf_slave spi_rf_checker #(.NREG(NREG), .DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .sclk_fall (sclk_fall),
    .state     (state),
    .ptr       (ptr),
    .ptr_adv   (ptr_adv),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .regs      (regs)
);

// File: tb/test_spi_rf_slave.sv
module test_spi_rf_slave;
    localparam int NREG = 12;
    localparam int DW   = 8;
    localparam int H    = 8;   // clk cycles per SCLK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NREG*DW-1:0] regs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [NREG];
    logic [7:0] rbuf [4];
    bit oe_any, oe_all;

    always #10 clk = ~clk;

    spi_rf_slave #(.NREG(NREG), .DW(DW)) i_spi_rf_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .regs(regs)
    );

    task automatic chk(input string tag, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [NREG*DW-1:0] model_flat();
        logic [NREG*DW-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    function automatic int nxt(input int p);
        return (p >= NREG - 1) ? 0 : p + 1;
    endfunction

    // send the top n bits of mosi, capture sdo before each rising edge
    task automatic spi_bits(input logic [7:0] mosi, input int n, output logic [7:0] miso);
        miso = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            sdi = mosi[i];
            repeat (H) @(negedge clk);
            miso[i] = sdo;
            oe_any |= sdo_oe;
            oe_all &= sdo_oe;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_off(input string tag);
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        #1;
        chk(tag, {95'd0, sdo_oe}, '0);
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic spi_write(input int a, input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] dummy;
        logic [7:0] d [3];
        int p;
        d[0] = d0; d[1] = d1; d[2] = d2;
        cs_on();
        spi_bits({a[6:0], 1'b0}, 8, dummy);
        oe_any = 1'b0;
        p = a;
        for (int k = 0; k < n; k++) begin
            spi_bits(d[k], 8, dummy);
            if (p < NREG) model[p] = d[k];
            p = nxt(p);
        end
        chk("R8 oe low during write", {95'd0, oe_any}, '0);
        cs_off("R8 oe off at cs release");
    endtask

    task automatic spi_read(input int a, input int n, input logic [7:0] fill);
        logic [7:0] v;
        cs_on();
        oe_any = 1'b0;
        spi_bits({a[6:0], 1'b1}, 8, v);
        chk("R8 oe low in command byte", {95'd0, oe_any}, '0);
        oe_all = 1'b1;
        for (int k = 0; k < n; k++) begin
            spi_bits(fill, 8, v);
            rbuf[k] = v;
        end
        chk("R8 oe high in read data", {95'd0, oe_all}, {95'd0, 1'b1});
        cs_off("R8 oe off after read");
    endtask

    task automatic t_reset();
        chk("R1 regs zero after reset", regs, '0);
        chk("R1 oe low after reset", {95'd0, sdo_oe}, '0);
    endtask

    task automatic t_single_write();
        spi_write(3, 1, 8'hA5, 8'h00, 8'h00);
        chk("R2 single write reg3", regs, model_flat());
    endtask

    task automatic t_burst_write();
        spi_write(2, 3, 8'h11, 8'h22, 8'h33);
        chk("R3 burst write regs 2..4", regs, model_flat());
    endtask

    task automatic t_wrap_write();
        spi_write(10, 3, 8'hC1, 8'hC2, 8'hC3);
        chk("R4 wrap write 10,11,0", regs, model_flat());
    endtask

    task automatic t_single_read();
        spi_read(3, 1, 8'h00);
        chk("R5 read reg3", {88'd0, rbuf[0]}, {88'd0, model[3]});
    endtask

    task automatic t_burst_read();
        spi_read(11, 3, 8'hFF);
        chk("R6 read burst byte0 reg11", {88'd0, rbuf[0]}, {88'd0, model[11]});
        chk("R6 read burst byte1 reg0", {88'd0, rbuf[1]}, {88'd0, model[0]});
        chk("R6 read burst byte2 reg1", {88'd0, rbuf[2]}, {88'd0, model[1]});
        chk("R7 sdi ignored in read", regs, model_flat());
    endtask

    task automatic t_invalid();
        spi_write(20, 1, 8'h5A, 8'h00, 8'h00);
        chk("R10 write to addr 20 ignored", regs, model_flat());
        spi_read(12, 2, 8'h00);
        chk("R10 read addr 12 gives zero", {88'd0, rbuf[0]}, '0);
        chk("R10 pointer wraps from 12 to 0", {88'd0, rbuf[1]}, {88'd0, model[0]});
    endtask

    task automatic t_partial_data();
        logic [7:0] dummy;
        cs_on();
        spi_bits({7'd6, 1'b0}, 8, dummy);
        spi_bits(8'hFF, 5, dummy);
        cs_off("R8 oe off after partial");
        chk("R9 partial byte discarded", regs, model_flat());
    endtask

    task automatic t_abort_cmd();
        logic [7:0] dummy;
        cs_on();
        spi_bits(8'hFF, 3, dummy);
        cs_off("R8 oe off after abort");
        spi_write(5, 1, 8'h3C, 8'h00, 8'h00);
        chk("R11 transfer after aborted command", regs, model_flat());
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_burst_write();
        t_wrap_write();
        t_single_read();
        t_burst_read();
        t_invalid();
        t_partial_data();
        t_abort_cmd();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule